// File: doc/BRIEF.md
# Programmable-Threshold FIFO with Wrap Mode

A single-clock first-in first-out buffer of 4096 twelve-bit words. Every control input is active low. Each cycle the block can accept a write and a read. It reports its fill state on four flags:

- `full_n`, low when the buffer is full.
- `empty_n`, low when the buffer is empty.
- `afull_n`, low when the buffer is nearly full.
- `aempty`, high once enough words are queued.

The nearly-full and enough-words levels come from two threshold registers. These are loaded through the data input by holding a load strobe low during a write cycle. A select bit picks which register is written.

The write pointer and the read pointer each have their own reset input. The enable levels present while a pointer reset is applied choose the operating mode:

- **Guarded mode.** Writes are refused while full and reads are refused while empty.
- **Wrap mode.** Every enabled access executes, the pointers wrap freely, and the flags are advisory only. This suits recirculating or overwrite-oldest use.

Top module: `pflag_fifo`

## Requirements
- R1: While `rst_n` is low the block enters guarded mode with both pointers at 0 and both thresholds at 0. After release: `empty_n`=0, `full_n`=1, `afull_n`=1, `aempty`=0 and `dout`=0.
- R2: In guarded mode, words leave in the order they were written. `dout` is registered and changes on the clock edge of an executed read, which is `rd_en_n` low while not empty. Otherwise it holds the last word read.
- R3: `full_n` is low exactly when 4096 words are held. In guarded mode a write while full is discarded.
- R4: `empty_n` is low exactly when no word is held. In guarded mode a read while empty is discarded and `dout` keeps its value.
- R5: `afull_n` is low when the occupancy is at least 4096 − A, where A is the almost-full threshold.
- R6: `aempty` is high when the occupancy is at least E + 1, where E is the almost-empty threshold.
- R7: A cycle with `load_n`=0 and `wr_en_n`=0 copies `din` bit for bit into a threshold register: the almost-empty threshold when `thr_sel`=0, the almost-full threshold when `thr_sel`=1. Such a cycle pushes no word.
- R8: A cycle with `wptr_rst_n`=0 or `rptr_rst_n`=0 returns that pointer to location 0 and clears the occupancy. No write executes while the write pointer is being reset, and no read executes while the read pointer is being reset.
- R9: A pointer reset applied with its own enable high selects guarded behaviour for that side. Wrap mode is active while either side's last reset saw its enable low.
- R10: In wrap mode every enabled access executes. A write while full overwrites the oldest unread word and the occupancy stays at 4096. A read while empty still advances the read pointer and loads `dout`.
- R11: In guarded mode a simultaneous write and read leaves the occupancy unchanged. When empty only the write executes, and when full only the read executes.
- R12: All four flags follow the occupancy and thresholds as they stand after each clock edge, so they change on the same edge as the access that altered the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous block reset, active low |
| wr_en_n | input | 1 | Write enable, active low |
| rd_en_n | input | 1 | Read enable, active low |
| wptr_rst_n | input | 1 | Write-pointer reset, active low |
| rptr_rst_n | input | 1 | Read-pointer reset, active low |
| load_n | input | 1 | Threshold load strobe, active low |
| thr_sel | input | 1 | Threshold select: 0 almost-empty, 1 almost-full |
| din | input | 12 | Write data or threshold value |
| dout | output | 12 | Registered read data |
| full_n | output | 1 | Full flag, active low |
| empty_n | output | 1 | Empty flag, active low |
| afull_n | output | 1 | Almost-full flag, active low |
| aempty | output | 1 | Occupancy above the almost-empty threshold, active high |

## Verification
A write and a read can land in the same cycle, and at the empty and full boundaries the guarded mode must then let only one of them through. The bench provokes this in three places:

- A combined access in the middle of the buffer, where the flags must stay put.
- A combined access while empty, where the new word is accepted but `dout` holds.
- A combined access while full with a marker value, where the oldest word appears on `dout` and `full_n` rises.

In the full case, the marker must never surface during the drain that follows, which is judged against a reference queue.

// File: rtl/pflag_fifo_pkg.sv
package pflag_fifo_pkg;

    typedef enum logic {
        SEL_AEMPTY = 1'b0,
        SEL_AFULL  = 1'b1
    } thr_sel_e;

    typedef struct packed {
        logic full_n;
        logic empty_n;
        logic afull_n;
        logic aempty;
    } flags_t;

endpackage

// File: rtl/pflag_fifo_thresh.sv
module pflag_fifo_thresh
    import pflag_fifo_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_go,
    input  logic              sel,
    input  logic [ADDR_W-1:0] value,
    output logic [ADDR_W-1:0] ae_thr,
    output logic [ADDR_W-1:0] af_thr
);

    typedef struct packed {
        logic [ADDR_W-1:0] ae;
        logic [ADDR_W-1:0] af;
    } thr_t;

    thr_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load_go) begin
            if (thr_sel_e'(sel) == SEL_AFULL) s_d.af = value;
            else                              s_d.ae = value;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ae_thr = s_q.ae;
    assign af_thr = s_q.af;

endmodule

// File: rtl/pflag_fifo_mem.sv
module pflag_fifo_mem #(
    parameter int WIDTH  = 12,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WIDTH-1:0]  rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [WIDTH-1:0] store [DEPTH];
    logic [WIDTH-1:0] dout_d, dout_q;

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    always_comb begin
        dout_d = dout_q;
        if (re) dout_d = store[raddr];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dout_q <= '0;
        else        dout_q <= dout_d;
    end

    assign rdata = dout_q;

endmodule

// File: rtl/pflag_fifo_ctrl.sv
module pflag_fifo_ctrl
    import pflag_fifo_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_n,
    input  logic              rd_en_n,
    input  logic              wptr_rst_n,
    input  logic              rptr_rst_n,
    input  logic              load_n,
    input  logic [ADDR_W-1:0] ae_thr,
    input  logic [ADDR_W-1:0] af_thr,
    output logic              wr_go,
    output logic              rd_go,
    output logic [ADDR_W-1:0] waddr,
    output logic [ADDR_W-1:0] raddr,
    output logic              guarded,
    output flags_t            flags
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int CNT_W = ADDR_W + 1;
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    typedef struct packed {
        logic [ADDR_W-1:0] wptr;
        logic [ADDR_W-1:0] rptr;
        logic [CNT_W-1:0]  count;
        logic              wr_wrap;
        logic              rd_wrap;
    } ctrl_t;

    ctrl_t s_d, s_q;

    logic wr_rst, rd_rst, push_req, pop_req, wrap, is_full, is_empty;

    always_comb begin
        wr_rst   = !wptr_rst_n;
        rd_rst   = !rptr_rst_n;
        push_req = !wr_en_n && load_n && !wr_rst;
        pop_req  = !rd_en_n && !rd_rst;
        wrap     = s_q.wr_wrap || s_q.rd_wrap;
        is_full  = (s_q.count == CNT_FULL);
        is_empty = (s_q.count == '0);
        wr_go    = push_req && (wrap || !is_full);
        rd_go    = pop_req && (wrap || !is_empty);

        s_d = s_q;
        if (wr_rst) begin
            s_d.wptr    = '0;
            s_d.wr_wrap = !wr_en_n;
        end else if (wr_go) begin
            s_d.wptr = s_q.wptr + 1'b1;
        end
        if (rd_rst) begin
            s_d.rptr    = '0;
            s_d.rd_wrap = !rd_en_n;
        end else if (rd_go) begin
            s_d.rptr = s_q.rptr + 1'b1;
        end

        if (wr_rst || rd_rst) begin
            s_d.count = '0;
        end else if (wr_go && !rd_go) begin
            if (!is_full) s_d.count = s_q.count + 1'b1;
        end else if (rd_go && !wr_go) begin
            if (!is_empty) s_d.count = s_q.count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        flags.full_n  = !is_full;
        flags.empty_n = !is_empty;
        flags.afull_n = !(s_q.count >= (CNT_FULL - {1'b0, af_thr}));
        flags.aempty  = (s_q.count > {1'b0, ae_thr});
    end

    assign waddr   = s_q.wptr;
    assign raddr   = s_q.rptr;
    assign guarded = !wrap;

    // R3: a guarded write into a full buffer leaves it full
    p_full_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (guarded && !flags.full_n && !wr_en_n && load_n && rd_en_n && wptr_rst_n && rptr_rst_n)
        |=> !flags.full_n);

    // R8: a write-pointer reset empties the buffer
    p_ptr_reset_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wptr_rst_n |=> !flags.empty_n);

    // R10: a wrap-mode write while full keeps the buffer full
    p_wrap_saturate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!guarded && !flags.full_n && !wr_en_n && load_n && rd_en_n && wptr_rst_n && rptr_rst_n)
        |=> !flags.full_n);

    // R5: whenever full, the almost-full flag is also asserted
    p_full_implies_afull_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !flags.full_n |-> !flags.afull_n);

    // R6: whenever empty, the almost-empty indicator is low
    p_empty_no_aempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !flags.empty_n |-> !flags.aempty);

endmodule

// File: rtl/pflag_fifo.sv
module pflag_fifo
    import pflag_fifo_pkg::*;
#(
    parameter int WIDTH  = 12,
    parameter int ADDR_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_n,
    input  logic             rd_en_n,
    input  logic             wptr_rst_n,
    input  logic             rptr_rst_n,
    input  logic             load_n,
    input  logic             thr_sel,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             full_n,
    output logic             empty_n,
    output logic             afull_n,
    output logic             aempty
);

    logic [ADDR_W-1:0] ae_thr, af_thr, waddr, raddr;
    logic              wr_go, rd_go, guarded, load_go;
    flags_t            flags;

    assign load_go = !load_n && !wr_en_n;

    pflag_fifo_thresh #(.ADDR_W(ADDR_W)) u_thresh (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_go(load_go),
        .sel    (thr_sel),
        .value  (din[ADDR_W-1:0]),
        .ae_thr (ae_thr),
        .af_thr (af_thr)
    );

    pflag_fifo_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_n   (wr_en_n),
        .rd_en_n   (rd_en_n),
        .wptr_rst_n(wptr_rst_n),
        .rptr_rst_n(rptr_rst_n),
        .load_n    (load_n),
        .ae_thr    (ae_thr),
        .af_thr    (af_thr),
        .wr_go     (wr_go),
        .rd_go     (rd_go),
        .waddr     (waddr),
        .raddr     (raddr),
        .guarded   (guarded),
        .flags     (flags)
    );

    pflag_fifo_mem #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_mem (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (wr_go),
        .waddr(waddr),
        .wdata(din),
        .re   (rd_go),
        .raddr(raddr),
        .rdata(dout)
    );

    assign full_n  = flags.full_n;
    assign empty_n = flags.empty_n;
    assign afull_n = flags.afull_n;
    assign aempty  = flags.aempty;

    // R4: a guarded read of an empty buffer leaves the output untouched
    p_empty_read_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (guarded && !empty_n && !rd_en_n && rptr_rst_n && wptr_rst_n) |=> $stable(dout));

    // R7: a threshold load pushes nothing
    p_load_no_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n && !wr_en_n && rd_en_n && wptr_rst_n && rptr_rst_n)
        |=> ($stable(empty_n) && $stable(full_n)));

endmodule

// File: tb/pflag_fifo_bench.sv
module pflag_fifo_bench;

    localparam int WIDTH = 12;
    localparam int DEPTH = 4096;

    logic clk = 1'b0;
    logic rst_n, wr_en_n, rd_en_n, wptr_rst_n, rptr_rst_n, load_n, thr_sel;
    logic [WIDTH-1:0] din, dout;
    logic full_n, empty_n, afull_n, aempty;

    int tests = 0;
    int fails = 0;
    logic [WIDTH-1:0] refq [$];

    always #4 clk = ~clk;

    pflag_fifo u_pflag_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .rd_en_n(rd_en_n),
        .wptr_rst_n(wptr_rst_n), .rptr_rst_n(rptr_rst_n), .load_n(load_n),
        .thr_sel(thr_sel), .din(din), .dout(dout), .full_n(full_n),
        .empty_n(empty_n), .afull_n(afull_n), .aempty(aempty)
    );

    typedef struct packed {
        logic        wr_n;
        logic        rd_n;
        logic        ld_n;
        logic        sel;
        logic [11:0] data;
        logic [11:0] exp_dout;
        logic [3:0]  exp_flags;   // {full_n, empty_n, afull_n, aempty}
    } vec_t;

    localparam vec_t TABLE [13] = '{
        '{1'b0, 1'b1, 1'b0, 1'b0, 12'd2,    12'h000, 4'b1010},
        '{1'b0, 1'b1, 1'b0, 1'b1, 12'd4093, 12'h000, 4'b1010},
        '{1'b0, 1'b1, 1'b1, 1'b0, 12'h111,  12'h000, 4'b1110},
        '{1'b0, 1'b1, 1'b1, 1'b0, 12'h222,  12'h000, 4'b1110},
        '{1'b0, 1'b1, 1'b1, 1'b0, 12'h333,  12'h000, 4'b1101},
        '{1'b1, 1'b0, 1'b1, 1'b0, 12'h000,  12'h111, 4'b1110},
        '{1'b0, 1'b0, 1'b1, 1'b0, 12'h444,  12'h222, 4'b1110},
        '{1'b1, 1'b1, 1'b1, 1'b0, 12'h000,  12'h222, 4'b1110},
        '{1'b1, 1'b0, 1'b1, 1'b0, 12'h000,  12'h333, 4'b1110},
        '{1'b1, 1'b0, 1'b1, 1'b0, 12'h000,  12'h444, 4'b1010},
        '{1'b1, 1'b0, 1'b1, 1'b0, 12'h000,  12'h444, 4'b1010},
        '{1'b0, 1'b0, 1'b1, 1'b0, 12'h555,  12'h444, 4'b1110},
        '{1'b1, 1'b0, 1'b1, 1'b0, 12'h000,  12'h555, 4'b1010}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive one cycle of inputs at a falling edge, return at the next falling edge
    task automatic step(input logic wr, input logic rd, input logic ld, input logic sel,
                        input logic [11:0] d, input logic wrst, input logic rrst);
        wr_en_n = wr; rd_en_n = rd; load_n = ld; thr_sel = sel; din = d;
        wptr_rst_n = wrst; rptr_rst_n = rrst;
        @(negedge clk);
    endtask

    function automatic logic [11:0] fill_word(input int i);
        return 12'((i * 7 + 3) & 12'hFFF);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        wr_en_n = 1'b1; rd_en_n = 1'b1; load_n = 1'b1; thr_sel = 1'b0; din = '0;
        wptr_rst_n = 1'b1; rptr_rst_n = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 empty_n", 32'(empty_n), 0);
        chk("R1 full_n",  32'(full_n), 1);
        chk("R1 afull_n", 32'(afull_n), 1);
        chk("R1 aempty",  32'(aempty), 0);
        chk("R1 dout",    32'(dout), 0);

        // guarded pointer reset: both enables high (R9)
        step(1, 1, 1, 0, 0, 0, 0);
        step(1, 1, 1, 0, 0, 1, 1);

        // table: R7 loads, R2 ordering, R6/R5 thresholds, R11 combined access, R12 flags
        for (int i = 0; i < 13; i++) begin
            step(TABLE[i].wr_n, TABLE[i].rd_n, TABLE[i].ld_n, TABLE[i].sel, TABLE[i].data, 1, 1);
            chk($sformatf("R2 dout vec%0d", i), 32'(dout), 32'(TABLE[i].exp_dout));
            chk($sformatf("R12 flags vec%0d", i), 32'({full_n, empty_n, afull_n, aempty}),
                32'(TABLE[i].exp_flags));
        end

        // almost-full threshold A=10 -> asserted at occupancy 4086 (R5, R7)
        step(0, 1, 0, 1, 12'd10, 1, 1);
        chk("R7 load leaves empty", 32'(empty_n), 0);

        // fill to full (R3, R5)
        for (int i = 0; i < DEPTH; i++) begin
            step(0, 1, 1, 0, fill_word(i), 1, 1);
            refq.push_back(fill_word(i));
            if (i == 4084) chk("R5 afull_n below level", 32'(afull_n), 1);
            if (i == 4085) chk("R5 afull_n at level", 32'(afull_n), 0);
            if (i == 4094) chk("R3 full_n at 4095", 32'(full_n), 1);
            if (i == 4095) chk("R3 full_n at 4096", 32'(full_n), 0);
        end
        step(0, 1, 1, 0, 12'hFFF, 1, 1);
        chk("R3 full after blocked write", 32'(full_n), 0);

        // combined access while full: only the read executes (R11)
        step(0, 0, 1, 0, 12'hABC, 1, 1);
        chk("R11 read at full", 32'(dout), 32'(refq.pop_front()));
        chk("R11 full_n after combined", 32'(full_n), 1);

        // drain, comparing against the reference queue (R2)
        while (refq.size() > 0) begin
            step(1, 0, 1, 0, 0, 1, 1);
            chk("R2 drain order", 32'(dout), 32'(refq.pop_front()));
        end
        chk("R4 empty after drain", 32'(empty_n), 0);
        step(1, 0, 1, 0, 0, 1, 1);
        chk("R4 dout holds on empty read", 32'(dout), 32'(fill_word(DEPTH - 1)));

        // pointer reset with data queued (R8)
        step(0, 1, 1, 0, 12'h0AA, 1, 1);
        step(0, 1, 1, 0, 12'h0BB, 1, 1);
        step(1, 1, 1, 0, 0, 0, 0);
        chk("R8 empty after pointer reset", 32'(empty_n), 0);
        step(0, 1, 1, 0, 12'h321, 1, 1);
        step(1, 0, 1, 0, 0, 1, 1);
        chk("R8 read from location 0", 32'(dout), 32'h321);

        // wrap mode: resets with enables low (R9, R10)
        step(0, 0, 1, 0, 0, 0, 0);
        for (int i = 0; i < DEPTH; i++) step(0, 1, 1, 0, 12'(i) ^ 12'h5A5, 1, 1);
        chk("R10 full after wrap fill", 32'(full_n), 0);
        step(0, 1, 1, 0, 12'h777, 1, 1);
        chk("R10 stays full on overwrite", 32'(full_n), 0);
        step(1, 0, 1, 0, 0, 1, 1);
        chk("R10 oldest word overwritten", 32'(dout), 32'h777);

        step(0, 0, 1, 0, 0, 0, 0);
        step(1, 0, 1, 0, 0, 1, 1);
        chk("R10 empty read executes loc0", 32'(dout), 32'h777);
        step(1, 0, 1, 0, 0, 1, 1);
        chk("R10 empty read executes loc1", 32'(dout), 32'(12'd1 ^ 12'h5A5));

        // back to guarded mode (R9)
        step(1, 1, 1, 0, 0, 0, 0);
        step(1, 0, 1, 0, 0, 1, 1);
        chk("R9 guarded blocks empty read", 32'(dout), 32'(12'd1 ^ 12'h5A5));
        step(0, 1, 1, 0, 12'h123, 1, 1);
        step(1, 0, 1, 0, 0, 1, 1);
        chk("R9 guarded read", 32'(dout), 32'h123);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule